// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block holds the digital half of a dual-slope integrating converter. It sets the three analog switches around an external integrator: one connects the unknown input, one connects the fixed reference of opposite sign, and one shorts the integrator back to its rest level. A conversion has three phases. First the input is integrated for a programmed number of clock cycles. Then the reference is integrated, and a single counter times how long the integrator takes to return to its starting level. Finally the integrator is shorted for a programmed settling time.

The counter value captured when the comparator reports that the integrator is back at its starting level is the conversion result. It equals the input averaged over the first phase, scaled by the reference. If the counter reaches its ceiling before the comparator trips, the conversion is cut short and an overrange flag is returned. The block accepts a new start only when it is idle.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset all three switch outputs are low, and `done`, `overrange` and `result` are 0. While idle all switches stay open.
- R2: A `start` seen while idle makes `sw_input` the only closed switch from the next cycle. It stays closed for exactly max(`integ_len`,1) cycles.
- R3: Once the input phase ends, `sw_ref` is the only closed switch. The counter restarts at 0 on the first reference cycle and rises by one on each further reference cycle.
- R4: On the first reference cycle in which `at_base` is high, the counter value in that cycle is registered into `result`. `done` is high for exactly the following cycle, which is `L + result + 1` cycles after the accepting clock edge (L = max(`integ_len`,1)). `result` and `overrange` hold until the next `done`.
- R5: If the counter reaches 2^CNT_W-1 in the reference phase while `at_base` is still low, the conversion ends with `result` all ones and `overrange` = 1. A crossing seen in that same cycle takes precedence and gives `overrange` = 0.
- R6: The zero phase starts in the cycle in which `done` is high. `sw_zero` is then the only closed switch for exactly max(`settle_len`,1) cycles, after which the block is idle.
- R7: `start` has no effect outside the idle state. `integ_len` and `settle_len` are sampled only on the edge that accepts a start.
- R8: At most one switch output is high in any cycle.
- R9: Each conversion produces exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion (taken only when idle) |
| at_base | input | 1 | Comparator: integrator at or past its starting level |
| integ_len | input | CNT_W | Input integration length in cycles |
| settle_len | input | CNT_W | Zeroing length in cycles |
| sw_input | output | 1 | Close the input switch |
| sw_ref | output | 1 | Close the reference switch |
| sw_zero | output | 1 | Close the integrator short |
| result | output | CNT_W | Reference-phase count of the last conversion |
| overrange | output | 1 | Last conversion hit the counter ceiling |
| done | output | 1 | One-cycle pulse when result is registered |

## Verification
Call the edge that accepts `start` edge 0. The input switch is expected high from edge 0 through edge L-1, and the reference switch for the following result+1 cycles. `done`, `result` and `overrange` are due just after edge L+result+1. The zero switch must be closed for the settle count starting in that same cycle. The bench samples every output at the falling edge, numbers each sample by the rising edges that have passed since edge 0, and compares the edge at which `done` appears and the number of samples in each phase with values it computes by ceiling division of L·vin by vref. The sweep covers zero input, a crossing exactly at the counter ceiling, and overrange.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2,
    PH_ZERO  = 2'd3
  } phase_t;
endpackage

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/dsadc_len_regs.sv
module dsadc_len_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] integ_len_i,
  input  logic [W-1:0] settle_len_i,
  output logic [W-1:0] integ_q,
  output logic [W-1:0] settle_q
);
  logic [W-1:0] integ_d, settle_d;

  // Zero lengths are raised to one cycle so a phase always runs.
  always_comb begin
    integ_d  = (integ_len_i  == '0) ? W'(1) : integ_len_i;
    settle_d = (settle_len_i == '0) ? W'(1) : settle_len_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q  <= W'(1);
      settle_q <= W'(1);
    end else if (load) begin
      integ_q  <= integ_d;
      settle_q <= settle_d;
    end
  end
endmodule

// File: rtl/dsadc_phase_fsm.sv
module dsadc_phase_fsm
  import dsadc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_ok,
  input  logic   integ_end,
  input  logic   deint_end,
  input  logic   zero_end,
  output phase_t phase,
  output logic   sw_input,
  output logic   sw_ref,
  output logic   sw_zero
);
  phase_t phase_d;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_IDLE:  if (start_ok)  phase_d = PH_INTEG;
      PH_INTEG: if (integ_end) phase_d = PH_DEINT;
      PH_DEINT: if (deint_end) phase_d = PH_ZERO;
      PH_ZERO:  if (zero_end)  phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  always_comb begin
    sw_input = (phase == PH_INTEG);
    sw_ref   = (phase == PH_DEINT);
    sw_zero  = (phase == PH_ZERO);
  end
endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         ovf,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] result,
  output logic         overrange,
  output logic         done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      overrange <= 1'b0;
    end else if (capture) begin
      result    <= cnt;
      overrange <= ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= capture;
  end
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsadc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             at_base,
  input  logic [CNT_W-1:0] integ_len,
  input  logic [CNT_W-1:0] settle_len,
  output logic             sw_input,
  output logic             sw_ref,
  output logic             sw_zero,
  output logic [CNT_W-1:0] result,
  output logic             overrange,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] integ_q, settle_q;
  logic             start_ok, integ_end, deint_end, zero_end;
  logic             cnt_clr, cnt_inc, deint_ovf;

  always_comb begin
    start_ok  = (phase == PH_IDLE) && start;
    integ_end = (phase == PH_INTEG) && (cnt == integ_q - 1'b1);
    deint_ovf = !at_base && (cnt == CNT_MAX);
    deint_end = (phase == PH_DEINT) && (at_base || deint_ovf);
    zero_end  = (phase == PH_ZERO) && (cnt == settle_q - 1'b1);
    cnt_clr   = start_ok | integ_end | deint_end | zero_end;
    cnt_inc   = (phase != PH_IDLE);
  end

  dsadc_len_regs #(.W(CNT_W)) u_len (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (start_ok),
    .integ_len_i  (integ_len),
    .settle_len_i (settle_len),
    .integ_q      (integ_q),
    .settle_q     (settle_q)
  );

  dsadc_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  dsadc_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .integ_end (integ_end),
    .deint_end (deint_end),
    .zero_end  (zero_end),
    .phase     (phase),
    .sw_input  (sw_input),
    .sw_ref    (sw_ref),
    .sw_zero   (sw_zero)
  );

  dsadc_result #(.W(CNT_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (deint_end),
    .ovf       (deint_ovf),
    .cnt       (cnt),
    .result    (result),
    .overrange (overrange),
    .done      (done)
  );
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             sw_input,
  input logic             sw_ref,
  input logic             sw_zero,
  input logic [CNT_W-1:0] result,
  input logic             overrange,
  input logic             done
);
  p_one_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_input, sw_ref, sw_zero}) <= 1);

  p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_input && !sw_ref && !sw_zero && start) |=> sw_input);

  p_input_then_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_input) |-> sw_ref);

  p_ref_end_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_ref) |-> done);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(overrange)));

  p_ovr_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overrange) |-> (result == {CNT_W{1'b1}}));

  p_done_in_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sw_zero);

  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_ref || sw_zero) && start) |=> !sw_input);
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .sw_input  (sw_input),
  .sw_ref    (sw_ref),
  .sw_zero   (sw_zero),
  .result    (result),
  .overrange (overrange),
  .done      (done)
);

// File: tb/sim_dual_slope_seq.sv
module sim_dual_slope_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 6;
  localparam int MAXC       = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] integ_len = '0;
  logic [W-1:0] settle_len = '0;
  logic         sw_input, sw_ref, sw_zero, overrange, done;
  logic [W-1:0] result;
  logic         at_base;

  int checks = 0;
  int errors = 0;
  int vin = 0;
  int vref = 1;
  int acc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Integrator model: one step per clock according to the closed switch.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= 0;
    else if (sw_zero)  acc <= 0;
    else if (sw_input) acc <= acc + vin;
    else if (sw_ref)   acc <= acc - vref;
  end
  assign at_base = (acc <= 0);

  dual_slope_seq #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .at_base(at_base),
    .integ_len(integ_len), .settle_len(settle_len),
    .sw_input(sw_input), .sw_ref(sw_ref), .sw_zero(sw_zero),
    .result(result), .overrange(overrange), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int len, input int vi, input int vr, input int st);
    int L, S, r, ovr, idx, n_in, n_ref, n_zero, n_done, done_idx, res_got, ovr_got;
    bit ref_seen;
    L = (len == 0) ? 1 : len;
    S = (st == 0) ? 1 : st;
    r = (L * vi + vr - 1) / vr;
    ovr = 0;
    if (r > MAXC) begin r = MAXC; ovr = 1; end
    @(negedge clk);
    vin = vi; vref = vr;
    integ_len = W'(len); settle_len = W'(st); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    integ_len = W'(len + 7); settle_len = W'(st + 5);  // R7: must be ignored
    chk("R2 first cycle input-only", {sw_input, sw_ref, sw_zero}, 3'b100);
    idx = 0; n_in = 0; n_ref = 0; n_zero = 0; n_done = 0;
    done_idx = -1; res_got = -1; ovr_got = -1; ref_seen = 0;
    while (idx < 400) begin
      if (start) start = 1'b0;
      if (sw_input) n_in++;
      if (sw_ref) begin
        n_ref++;
        if (!ref_seen) begin ref_seen = 1; start = 1'b1; end  // R7: busy start
      end
      if (sw_zero) n_zero++;
      if (done) begin
        n_done++; done_idx = idx; res_got = int'(result); ovr_got = int'(overrange);
      end
      if (idx > 0 && !sw_input && !sw_ref && !sw_zero) break;
      @(posedge clk);
      @(negedge clk);
      idx++;
    end
    start = 1'b0;
    chk("R2 input phase length", n_in, L);
    chk("R3 reference phase length", n_ref, r + 1);
    chk("R4 result", res_got, r);
    chk("R5 overrange flag", ovr_got, ovr);
    chk("R4 done latency", done_idx, L + r + 1);
    chk("R6 zero phase length", n_zero, S);
    chk("R9 one done pulse", n_done, 1);
    repeat (3) begin
      chk("R7 stays idle after busy start", {sw_input, sw_ref, sw_zero, done}, 0);
      chk("R4 result held", int'(result), r);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens[6];
    int vrefs[3];
    lens = '{0, 1, 2, 5, 9, 16};
    vrefs = '{1, 3, 7};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 switches open in reset", {sw_input, sw_ref, sw_zero}, 0);
    chk("R1 done low", done, 0);
    chk("R1 result zero", int'(result), 0);
    chk("R1 overrange low", overrange, 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1 idle switches open", {sw_input, sw_ref, sw_zero, done}, 0);
    end
    // Sweep covers zero input, exact hit at ceiling (9*7/1=63) and overrange.
    foreach (lens[i]) begin
      for (int v = 0; v < 8; v++) begin
        foreach (vrefs[j]) begin
          run_conv(lens[i], v, vrefs[j], (v + i) % 4);
        end
      end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule